// File: doc/BRIEF.md
# Radio Transceiver Mode Sequencer

This block sits on the host side of a low-power packet radio link. It drives the transceiver's chip-enable line and decides when the host's SPI master may drop chip select, so that the radio's mode-change timing rules are always met. Firmware issues short commands (power up, send one packet, start continuous receive, start continuous transmit, stop). The sequencer turns each one into properly timed enable edges and reports progress through a busy flag and a ready flag.

All delays are counted in whole microseconds from a tick that a parameterised clock divider makes. The SPI shifter is outside the block: it raises a request and may only start a transaction while the grant is high. A supply-loss input returns the sequencer to the powered-down, unconfigured state. A configuration-done strobe must then arrive before any transmit or receive command is accepted.

Top module: `rsq_mode_seq`

## Requirements
- R1: Reset or a one-cycle `supply_lost` pulse puts the block into power down: `radio_ce`, `busy` and `ready` are low in the next cycle, and the configured flag is cleared.
- R2: A power-up command from power down holds `busy` high for exactly SETTLE*CLK_PER_US+1 cycles with `radio_ce` low. SETTLE is 1500 µs for `settle_sel`=0, 150 µs for 1, 3000 µs for 2 and 4500 µs for 3.
- R3: Send-one (`cmd_op`=1) from standby raises `radio_ce` for exactly 10*CLK_PER_US+1 cycles and then lowers it. `busy` stays high for 130*CLK_PER_US+1 cycles from the first enable cycle, and the block then returns to idle standby.
- R4: For the first 4*CLK_PER_US cycles after `radio_ce` rises, `spi_gnt` is low. At every other time `spi_gnt` equals `spi_req`.
- R5: In continuous receive (`cmd_op`=2) or continuous transmit (`cmd_op`=3), `ready` rises exactly 130*CLK_PER_US cycles after `radio_ce` rises, and `busy` stays low.
- R6: A send or receive command accepted in power down first performs the full power-up wait of R2, with `radio_ce` low, and only then raises `radio_ce`.
- R7: Continuous transmit holds `radio_ce` high for exactly TX_MAX_US*CLK_PER_US+1 cycles and then releases it on its own. The default TX_MAX_US of 3900 keeps this below 4 ms.
- R8: A command that arrives while `busy` is high is rejected. `cmd_err` is high for one cycle and the command is not kept for later.
- R9: Send, receive and continuous-transmit commands (`cmd_op` 1, 2, 3) are rejected with `cmd_err` until a `cfg_done` strobe has been seen since the last reset or supply loss.
- R10: Stop (`cmd_op`=4) in continuous receive or continuous transmit lowers `radio_ce` and `ready` in the next cycle. In those modes, any other command is rejected with `cmd_err`.
- R11: Operation codes 5 to 7 are always rejected with `cmd_err`. Power up (`cmd_op`=0) and stop are accepted without effect in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_lost | input | 1 | Radio supply dropped; forces power down and unconfigured |
| cfg_done | input | 1 | Strobe: radio registers have been written |
| settle_sel | input | 2 | Power-up settle time select (0:1500, 1:150, 2:3000, 3:4500 µs) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 power up, 1 send one, 2 receive, 3 continuous transmit, 4 stop) |
| spi_req | input | 1 | SPI master wants to lower chip select |
| spi_gnt | output | 1 | Chip select may go low |
| radio_ce | output | 1 | Chip-enable pin to the transceiver |
| busy | output | 1 | A timed sequence is running; commands are refused |
| ready | output | 1 | Radio has been active long enough to be transmitting or receiving |
| cmd_err | output | 1 | One-cycle pulse: last command rejected |

## Verification
The bench measures every timed window to the exact cycle at all four settle selections, so a divider that is off by one tick or a comparison that ends one count early shows up as a wrong cycle count. It sends commands during the settle wait and during receive, and then checks that the enable never rises afterwards. A design that queued rejected commands would raise the enable after the settle wait anyway. It holds `spi_req` high across a send-one pulse and counts refused grants, which catches a hold-off window that is missing or timed from a free-running tick. It also checks that a supply loss clears the configured state, which a design that kept the flag would show by accepting the next transmit.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int unsigned US_W = 13;   // holds 4500 µs and the transmit limit

    typedef enum logic [2:0] {
        OP_PWRUP = 3'd0,
        OP_SEND1 = 3'd1,
        OP_RX    = 3'd2,
        OP_TXC   = 3'd3,
        OP_STOP  = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_PD, ST_SETTLE, ST_STBY, ST_PULSE, ST_TAIL, ST_RX, ST_TXC
    } st_e;

    typedef enum logic [1:0] {
        GO_NONE, GO_SEND1, GO_RX, GO_TXC
    } goal_e;

    localparam logic [US_W-1:0] HOLD_US    = US_W'(10);
    localparam logic [US_W-1:0] CSN_GAP_US = US_W'(4);
    localparam logic [US_W-1:0] ACTIVE_US  = US_W'(130);

    function automatic logic [US_W-1:0] settle_us(input logic [1:0] sel);
        case (sel)
            2'd1:    return US_W'(150);
            2'd2:    return US_W'(3000);
            2'd3:    return US_W'(4500);
            default: return US_W'(1500);
        endcase
    endfunction

    function automatic goal_e op_goal(input logic [2:0] op);
        case (op)
            OP_SEND1: return GO_SEND1;
            OP_RX:    return GO_RX;
            OP_TXC:   return GO_TXC;
            default:  return GO_NONE;
        endcase
    endfunction

    function automatic st_e goal_state(input goal_e g);
        case (g)
            GO_SEND1: return ST_PULSE;
            GO_RX:    return ST_RX;
            GO_TXC:   return ST_TXC;
            default:  return ST_STBY;
        endcase
    endfunction

endpackage

// File: rtl/rsq_us_timer.sv
module rsq_us_timer #(
    parameter int unsigned CLK_PER_US = 16,
    parameter int unsigned W          = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] us
);
    localparam int unsigned PW = $clog2(CLK_PER_US + 1);
    localparam logic [PW-1:0] PRE_TOP = PW'(CLK_PER_US - 1);

    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre <= '0;
            us  <= '0;
        end else if (pre == PRE_TOP) begin
            pre <= '0;
            if (us != {W{1'b1}}) us <= us + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/rsq_cmd_gate.sv
module rsq_cmd_gate
    import rsq_pkg::*;
(
    input  st_e        st,
    input  logic       cfg_ok,
    input  logic [2:0] op,
    output logic       accept
);
    always_comb begin
        accept = 1'b0;
        case (st)
            ST_PD, ST_STBY: begin
                case (op)
                    OP_PWRUP, OP_STOP:      accept = 1'b1;
                    OP_SEND1, OP_RX, OP_TXC: accept = cfg_ok;
                    default:                accept = 1'b0;
                endcase
            end
            ST_RX, ST_TXC: accept = (op == OP_STOP);
            default:       accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/rsq_mode_seq.sv
module rsq_mode_seq
    import rsq_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 16,
    parameter int unsigned TX_MAX_US  = 3900
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_lost,
    input  logic       cfg_done,
    input  logic [1:0] settle_sel,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       spi_req,
    output logic       spi_gnt,
    output logic       radio_ce,
    output logic       busy,
    output logic       ready,
    output logic       cmd_err
);
    localparam logic [US_W-1:0] TXC_LIM = US_W'(TX_MAX_US);

    st_e             st, st_n;
    goal_e           goal, goal_n;
    logic            cfg_ok;
    logic            accept, take, clr;
    logic            hard_rst;
    logic [US_W-1:0] us;

    assign hard_rst = rst | supply_lost;

    rsq_us_timer #(.CLK_PER_US(CLK_PER_US), .W(US_W)) u_timer (
        .clk (clk),
        .rst (hard_rst),
        .clr (clr),
        .us  (us)
    );

    rsq_cmd_gate u_gate (
        .st     (st),
        .cfg_ok (cfg_ok),
        .op     (cmd_op),
        .accept (accept)
    );

    assign take = cmd_valid & accept;

    always_comb begin
        st_n   = st;
        goal_n = goal;
        clr    = 1'b0;
        case (st)
            ST_PD, ST_STBY: begin
                if (take && cmd_op != OP_STOP) begin
                    if (st == ST_PD) begin
                        st_n   = ST_SETTLE;
                        goal_n = op_goal(cmd_op);
                        clr    = 1'b1;
                    end else if (cmd_op != OP_PWRUP) begin
                        st_n = goal_state(op_goal(cmd_op));
                        clr  = 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (us >= settle_us(settle_sel)) begin
                    st_n   = goal_state(goal);
                    goal_n = GO_NONE;
                    clr    = 1'b1;
                end
            end
            ST_PULSE: if (us >= HOLD_US)   st_n = ST_TAIL;
            ST_TAIL:  if (us >= ACTIVE_US) st_n = ST_STBY;
            ST_RX:    if (take)            st_n = ST_STBY;
            ST_TXC: begin
                if (take || us >= TXC_LIM) st_n = ST_STBY;
            end
            default: st_n = ST_PD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (hard_rst) begin
            st      <= ST_PD;
            goal    <= GO_NONE;
            cfg_ok  <= 1'b0;
            cmd_err <= 1'b0;
        end else begin
            st      <= st_n;
            goal    <= goal_n;
            cfg_ok  <= cfg_ok | cfg_done;
            cmd_err <= cmd_valid & ~accept;
        end
    end

    logic ce_state, csn_hold;
    assign ce_state = (st == ST_PULSE) || (st == ST_RX) || (st == ST_TXC);
    assign csn_hold = ce_state && (us < CSN_GAP_US);

    assign radio_ce = ce_state;
    assign busy     = (st == ST_SETTLE) || (st == ST_PULSE) || (st == ST_TAIL);
    assign ready    = ((st == ST_RX) || (st == ST_TXC)) && (us >= ACTIVE_US);
    assign spi_gnt  = spi_req & ~csn_hold;

endmodule

// File: rtl/rsq_mode_seq_chk.sv
module rsq_mode_seq_chk
    import rsq_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 16,
    parameter int unsigned TX_MAX_US  = 3900
) (
    input logic       clk,
    input logic       rst,
    input logic       supply_lost,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       spi_gnt,
    input logic       radio_ce,
    input logic       busy,
    input logic       ready,
    input logic       cmd_err,
    input st_e        st
);
    localparam logic [31:0] GAP_CYC = 32'(4 * CLK_PER_US);
    localparam logic [31:0] ACT_CYC = 32'(130 * CLK_PER_US);
    localparam logic [31:0] TXL_CYC = 32'(4000 * CLK_PER_US);

    logic        ce_prev;
    logic [31:0] hi_cyc, hi_now, txc_cyc;

    assign hi_now = (radio_ce && !ce_prev) ? 32'd0 : hi_cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_prev <= 1'b0;
            hi_cyc  <= 32'd0;
            txc_cyc <= 32'd0;
        end else begin
            ce_prev <= radio_ce;
            if (radio_ce && !ce_prev)     hi_cyc <= 32'd1;
            else if (hi_cyc != '1)        hi_cyc <= hi_cyc + 32'd1;
            if (st == ST_TXC)             txc_cyc <= txc_cyc + 32'd1;
            else                          txc_cyc <= 32'd0;
        end
    end

    a_r1_loss_forces_down: assert property (@(posedge clk) disable iff (rst)
        supply_lost |=> (!radio_ce && !busy && !ready));

    a_r4_csn_holdoff: assert property (@(posedge clk) disable iff (rst)
        (spi_gnt && radio_ce) |-> (hi_now >= GAP_CYC));

    a_r5_ready_late: assert property (@(posedge clk) disable iff (rst)
        ready |-> (radio_ce && hi_now >= ACT_CYC && !busy));

    a_r7_tx_under_limit: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TXC) |-> (txc_cyc < TXL_CYC));

    a_r8_busy_rejects: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy && !supply_lost) |=> cmd_err);

    a_r10_stop_drops_ce: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_STOP && (st == ST_RX || st == ST_TXC) && !supply_lost)
        |=> (!radio_ce && !ready));

endmodule

bind rsq_mode_seq rsq_mode_seq_chk #(
    .CLK_PER_US (CLK_PER_US),
    .TX_MAX_US  (TX_MAX_US)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .supply_lost (supply_lost),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .spi_gnt     (spi_gnt),
    .radio_ce    (radio_ce),
    .busy        (busy),
    .ready       (ready),
    .cmd_err     (cmd_err),
    .st          (st)
);

// File: tb/tb_rsq_mode_seq.sv
module tb_rsq_mode_seq;
    localparam int CLK_PERIOD = 10;
    localparam int D          = 2;
    localparam int TXMAX      = 3900;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_lost = 1'b0;
    logic       cfg_done = 1'b0;
    logic [1:0] settle_sel = 2'd1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic       spi_req = 1'b0;
    logic       spi_gnt, radio_ce, busy, ready, cmd_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsq_mode_seq #(.CLK_PER_US(D), .TX_MAX_US(TXMAX)) dut (
        .clk(clk), .rst(rst), .supply_lost(supply_lost), .cfg_done(cfg_done),
        .settle_sel(settle_sel), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .spi_req(spi_req), .spi_gnt(spi_gnt), .radio_ce(radio_ce),
        .busy(busy), .ready(ready), .cmd_err(cmd_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op);
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic lose_supply();
        @(negedge clk); supply_lost = 1'b1;
        @(negedge clk); supply_lost = 1'b0;
    endtask

    task automatic configure();
        @(negedge clk); cfg_done = 1'b1;
        @(negedge clk); cfg_done = 1'b0;
    endtask

    task automatic run_busy(output int nb, output int nce, output int nblk);
        nb = 0; nce = 0; nblk = 0;
        while (busy && nb < 20000) begin
            nb++;
            if (radio_ce) begin
                nce++;
                if (!spi_gnt) nblk++;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset ce", radio_ce, 0);
        check("R1 reset busy", busy, 0);
        check("R1 reset ready", ready, 0);
        check("R1 reset err", cmd_err, 0);
        spi_req = 1'b1; #1;
        check("R4 grant while idle", spi_gnt, 1);
        spi_req = 1'b0;
    endtask

    task automatic t_settle(input logic [1:0] sel, input int us);
        int nb, nce, nblk;
        lose_supply();
        settle_sel = sel;
        issue(3'd0);
        check("R2 pwrup accepted", cmd_err, 0);
        run_busy(nb, nce, nblk);
        check($sformatf("R2 settle cycles sel%0d", sel), nb, us*D + 1);
        check("R2 ce low in settle", nce, 0);
        check("R2 ce low after", radio_ce, 0);
    endtask

    task automatic t_reject_busy();
        int nb, nce, nblk;
        lose_supply();
        configure();
        settle_sel = 2'd1;
        issue(3'd0);
        issue(3'd1);
        check("R8 err on busy", cmd_err, 1);
        @(negedge clk);
        check("R8 err one cycle", cmd_err, 0);
        run_busy(nb, nce, nblk);
        check("R8 not queued ce", nce, 0);
        repeat (4) @(negedge clk);
        check("R8 stays standby", radio_ce, 0);
        issue(3'd0);
        check("R11 pwrup in standby ok", cmd_err, 0);
        check("R11 pwrup no effect", busy, 0);
        issue(3'd5);
        check("R11 op5 rejected", cmd_err, 1);
        issue(3'd7);
        check("R11 op7 rejected", cmd_err, 1);
    endtask

    task automatic t_send1();
        int nb, nce, nblk;
        spi_req = 1'b1;
        issue(3'd1);
        check("R3 send accepted", cmd_err, 0);
        run_busy(nb, nce, nblk);
        check("R3 ce high cycles", nce, 10*D + 1);
        check("R3 busy cycles", nb, 130*D + 1);
        check("R4 blocked grants", nblk, 4*D);
        check("R3 back to idle ce", radio_ce, 0);
        check("R4 grant after", spi_gnt, 1);
        spi_req = 1'b0;
        issue(3'd4);
        check("R11 stop in standby ok", cmd_err, 0);
    endtask

    task automatic t_cfg_rx();
        int nb, nce, nblk, nr;
        lose_supply();
        settle_sel = 2'd1;
        issue(3'd2);
        check("R9 rx before cfg rejected", cmd_err, 1);
        check("R9 no settle started", busy, 0);
        configure();
        issue(3'd2);
        check("R9 rx after cfg ok", cmd_err, 0);
        run_busy(nb, nce, nblk);
        check("R6 settle before rx", nb, 150*D + 1);
        check("R6 ce low in settle", nce, 0);
        check("R6 ce high after", radio_ce, 1);
        nr = 0;
        while (!ready && nr < 5000) begin
            if (busy) check("R5 busy in rx", busy, 0);
            nr++;
            @(negedge clk);
        end
        check("R5 ready delay rx", nr, 130*D);
        issue(3'd1);
        check("R10 send in rx rejected", cmd_err, 1);
        check("R10 rx keeps ce", radio_ce, 1);
        issue(3'd4);
        check("R10 stop drops ce", radio_ce, 0);
        check("R10 stop drops ready", ready, 0);
    endtask

    task automatic t_txc();
        int nce, nr;
        issue(3'd3);
        check("R7 txc accepted", cmd_err, 0);
        check("R5 txc not busy", busy, 0);
        nce = 0; nr = -1;
        while (radio_ce && nce < 10000) begin
            if (ready && nr < 0) nr = nce;
            nce++;
            @(negedge clk);
        end
        check("R7 txc ce cycles", nce, TXMAX*D + 1);
        check("R7 under 4ms", int'(nce < 4000*D), 1);
        check("R5 ready delay txc", nr, 130*D);
    endtask

    task automatic t_loss();
        issue(3'd2);
        repeat (300*D) @(negedge clk);
        check("R1 rx ready before loss", ready, 1);
        lose_supply();
        check("R1 loss ce", radio_ce, 0);
        check("R1 loss ready", ready, 0);
        check("R1 loss busy", busy, 0);
        issue(3'd3);
        check("R1 cfg cleared", cmd_err, 1);
        check("R1 no settle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_settle(2'd1, 150);
        t_settle(2'd0, 1500);
        t_settle(2'd3, 4500);
        t_settle(2'd2, 3000);
        t_reject_busy();
        t_send1();
        t_cfg_rx();
        t_txc();
        t_loss();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule